// File: doc/BRIEF.md
# Port Pin Function Override Arbiter

This block decides, for each of the 24 pins of three 8-pin GPIO ports, which source controls the pad: the plain GPIO registers, one of three movable peripherals, a serial audio link, radio status outputs, a port 0 analog-enable mask, the low-frequency crystal oscillator, or the debug link. The rules are layered and fixed. Debug has the highest rank. Next come the oscillator's analog claim, the audio link when it is enabled, the analog-enable mask and the radio status outputs. Peripherals ranked by priority bits come after those, and plain GPIO comes last.

The configuration sits in a small set of registers loaded through a write strobe. From those registers to the pad controls and the routed inputs the block is purely combinational. Pin `p` is numbered `port*8 + bit`. Each peripheral has two signals; signal `s` of peripheral `k` is bit `k*2+s` of the peripheral buses. The routed inputs return pad values to the peripherals, to the audio link, to the debug link and to a conversion-trigger output. A pin that is in analog mode returns 0 on every digital input path.

Top module: `pinmux_arbiter`

## Requirements
- R1: After reset every pin is a GPIO input: pad_oe and pad_analog are all zero. The oscillator-mode bit resets to 1 and all other configuration fields reset to 0.
- R2: A pin whose function-select bit is 0 (or is 1 with no peripheral mapped there) drives the data bit on pad_out and the direction bit on pad_oe, and gpio_in reflects pad_in.
- R3: When its function-select bit is 1, a pin carries the mapped peripheral's out and oe. That peripheral's per_in bit returns the pad value, and a per_in bit returns 0 when its peripheral does not own the pin. The map is: peripheral 0 on pins 10,11 (location 0) or 0,1 (location 1); peripheral 1 on 8,9 or 10,11; peripheral 2 on 6,7 or 10,11.
- R4: On a shared pin the priority bits decide the winner. Bit 0 set lets peripheral 1 beat 0 (clear: 0 beats 1). Bit 1 set lets 2 beat 1 (clear: 1 beats 2). Bit 2 set lets 2 beat 0 (clear: 0 beats 2).
- R5: When the priority bits form a cycle among the claimants, the lowest-numbered claimant wins.
- R6: With audio enabled, the audio link owns four pins in the order clock, word select, receive, transmit. Location 0 maps these to pins 12 to 15 and location 1 to pins 2 to 5. The link overrides GPIO, peripherals, analog-enable and radio on those pins. Clock and word select use the link's own oe, transmit always drives, and receive is an input.
- R7: An analog-enable bit set for port 0 pin b puts that pin in analog mode: pad_analog=1, pad_oe=0, and it returns 0 to gpio_in and to any peripheral.
- R8: Pins 13, 14 and 15 each have a 2-bit radio field. A nonzero field makes the pin output rf_status bit (pin-13) with oe=1. All radio fields are ignored while audio is enabled.
- R9: While the oscillator-mode bit is 0, pins 19 and 20 are analog whatever their other settings.
- R10: While dbg_active is 1, pin 17 drives dbg_dat_out with oe dbg_dat_oe and pin 18 is an input, whatever the select and direction bits. dbg_dat_in and dbg_clk_in return pins 17 and 18, and both are 0 when debug is inactive.
- R11: conv_trig equals pad_in[16] only when pin 16's select and direction bits are both 0, and is 0 otherwise.
- R12: A register updates on the clock edge where cfg_we is 1. Nothing changes without cfg_we, and writes to addresses 14 and 15 are ignored. The address map is: 0-2 select per port, 3-5 direction, 6-8 data, 9 analog-enable, 10 locations (bits 0-2 peripheral, bit 3 audio location, bit 4 audio enable), 11 priority, 12 radio fields (bits 1:0 pin 13, 3:2 pin 14, 5:4 pin 15), 13 oscillator-mode bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| pad_in | input | 24 | Pad input values |
| pad_out | output | 24 | Pad output values |
| pad_oe | output | 24 | Pad output enables |
| pad_analog | output | 24 | Pad analog-mode flags |
| gpio_in | output | 24 | Digital pad readback, 0 on analog pins |
| per_out | input | 6 | Peripheral output values |
| per_oe | input | 6 | Peripheral output enables |
| per_in | output | 6 | Pad values routed back to peripherals |
| aud_sck_out | input | 1 | Audio clock output |
| aud_sck_oe | input | 1 | Audio clock output enable |
| aud_ws_out | input | 1 | Audio word-select output |
| aud_ws_oe | input | 1 | Audio word-select output enable |
| aud_tx_out | input | 1 | Audio transmit data |
| aud_sck_in | output | 1 | Audio clock from pad |
| aud_ws_in | output | 1 | Audio word select from pad |
| aud_rx_in | output | 1 | Audio receive data from pad |
| dbg_active | input | 1 | Debug link active |
| dbg_dat_out | input | 1 | Debug data to host |
| dbg_dat_oe | input | 1 | Debug data direction, 1 drives |
| dbg_dat_in | output | 1 | Debug data from pad |
| dbg_clk_in | output | 1 | Debug clock from pad |
| rf_status | input | 3 | Radio status signals for pins 13 to 15 |
| conv_trig | output | 1 | External conversion trigger |

## Verification
The bench targets the three-way pin contention on pins 10 and 11. It uses orderings with a clear winner, pairwise orderings in which the unrelated priority bits must be ignored, and two cyclic orderings. A resolver that left out a pair, or that had no fallback, would put the wrong peripheral's value on the pad or route the pad to a loser. It also checks the overrides: audio above analog-enable and radio, analog mode silencing both the pad driver and the digital inputs, debug above the direction bits, and the trigger gating. A design with any of these layers in the wrong order would drive a pad that should be quiet, or leak pad data to the wrong consumer.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  parameter int NPORT  = 3;
  parameter int PW     = 8;
  parameter int NPER   = 3;
  parameter int NSIG   = 2;
  parameter int NRF    = 3;
  parameter int RFW    = 2;
  parameter int AW     = 4;
  parameter int DW     = 8;
  parameter int NROLE  = 4;

  localparam int NPIN   = NPORT * PW;
  localparam int PIDX_W = $clog2(NPER);

  localparam int PIN_TRIG = 2 * PW;
  localparam int PIN_DDAT = 2 * PW + 1;
  localparam int PIN_DCLK = 2 * PW + 2;
  localparam int PIN_XO0  = 2 * PW + 3;
  localparam int PIN_XO1  = 2 * PW + 4;
  localparam int PIN_RF0  = PW + 5;

  localparam int ADDR_FSEL = 0;
  localparam int ADDR_DIR  = ADDR_FSEL + NPORT;
  localparam int ADDR_ODAT = ADDR_DIR + NPORT;
  localparam int ADDR_AEN  = ADDR_ODAT + NPORT;
  localparam int ADDR_LOC  = ADDR_AEN + 1;
  localparam int ADDR_PRIO = ADDR_LOC + 1;
  localparam int ADDR_RF   = ADDR_PRIO + 1;
  localparam int ADDR_OSC  = ADDR_RF + 1;

  typedef enum logic [2:0] {
    SRC_GPIO, SRC_PER, SRC_RF, SRC_AEN, SRC_AUD, SRC_OSC, SRC_DBG
  } src_e;

  typedef struct packed {
    logic [NPORT-1:0][PW-1:0] fsel;
    logic [NPORT-1:0][PW-1:0] dir;
    logic [NPORT-1:0][PW-1:0] odat;
    logic [PW-1:0]            aen;
    logic [NPER-1:0]          per_loc;
    logic                     aud_loc;
    logic                     aud_en;
    logic [2:0]               prio;
    logic [NRF-1:0][RFW-1:0]  rf_cfg;
    logic                     osc_sel;
  } cfg_t;

  function automatic cfg_t cfg_reset_value();
    cfg_t c;
    c = '0;
    c.osc_sel = 1'b1;
    return c;
  endfunction

  // Pin index of signal s of peripheral k at location loc.
  function automatic int per_pin(int k, logic loc, int s);
    int base;
    case (k)
      0:       base = loc ? 0        : PW + 2;
      1:       base = loc ? PW + 2   : PW;
      default: base = loc ? PW + 2   : 6;
    endcase
    return base + s;
  endfunction

  // Pin index of audio role r (0 clock, 1 word select, 2 receive, 3 transmit).
  function automatic int aud_pin(logic loc, int r);
    return (loc ? 2 : PW + 4) + r;
  endfunction

  // Does claimant i beat claimant j under priority bits pr?
  function automatic logic beats(int i, int j, logic [2:0] pr);
    logic b;
    b = 1'b0;
    if      (i == 1 && j == 0) b = pr[0];
    else if (i == 0 && j == 1) b = !pr[0];
    else if (i == 2 && j == 1) b = pr[1];
    else if (i == 1 && j == 2) b = !pr[1];
    else if (i == 2 && j == 0) b = pr[2];
    else if (i == 0 && j == 2) b = !pr[2];
    return b;
  endfunction

  // Claimant that beats every other claimant; lowest claimant if none does.
  function automatic logic [PIDX_W-1:0] pick_winner(logic [NPER-1:0] cl, logic [2:0] pr);
    logic [PIDX_W-1:0] w;
    logic found;
    logic ok;
    w = '0;
    found = 1'b0;
    for (int i = 0; i < NPER; i++) begin
      ok = cl[i];
      for (int j = 0; j < NPER; j++)
        if (j != i && cl[j] && !beats(i, j, pr)) ok = 1'b0;
      if (ok && !found) begin
        w = PIDX_W'(i);
        found = 1'b1;
      end
    end
    if (!found)
      for (int i = NPER - 1; i >= 0; i--)
        if (cl[i]) w = PIDX_W'(i);
    return w;
  endfunction
endpackage

// File: rtl/pinmux_cfg_regs.sv
module pinmux_cfg_regs
  import pinmux_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output cfg_t          cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= cfg_reset_value();
    end else if (we) begin
      for (int p = 0; p < NPORT; p++) begin
        if (int'(addr) == ADDR_FSEL + p) cfg.fsel[p] <= wdata[PW-1:0];
        if (int'(addr) == ADDR_DIR + p)  cfg.dir[p]  <= wdata[PW-1:0];
        if (int'(addr) == ADDR_ODAT + p) cfg.odat[p] <= wdata[PW-1:0];
      end
      if (int'(addr) == ADDR_AEN) cfg.aen <= wdata[PW-1:0];
      if (int'(addr) == ADDR_LOC) begin
        cfg.per_loc <= wdata[NPER-1:0];
        cfg.aud_loc <= wdata[NPER];
        cfg.aud_en  <= wdata[NPER+1];
      end
      if (int'(addr) == ADDR_PRIO) cfg.prio <= wdata[2:0];
      if (int'(addr) == ADDR_RF)
        for (int k = 0; k < NRF; k++) cfg.rf_cfg[k] <= wdata[k*RFW +: RFW];
      if (int'(addr) == ADDR_OSC) cfg.osc_sel <= wdata[0];
    end
  end

  assert_hold_without_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg));
  assert_prio_write_lands_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(addr) == ADDR_PRIO) |=> cfg.prio == $past(wdata[2:0]));
endmodule

// File: rtl/pinmux_pin_resolve.sv
module pinmux_pin_resolve
  import pinmux_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dbg_claim,
  input  logic                 dbg_out,
  input  logic                 dbg_oe,
  input  logic                 osc_claim,
  input  logic                 aud_claim,
  input  logic                 aud_out,
  input  logic                 aud_oe,
  input  logic                 aen,
  input  logic                 rf_claim,
  input  logic                 rf_out,
  input  logic [NPER-1:0]      per_claim,
  input  logic [NPER-1:0]      per_out_v,
  input  logic [NPER-1:0]      per_oe_v,
  input  logic [2:0]           prio,
  input  logic                 fsel,
  input  logic                 dir,
  input  logic                 odat,
  input  logic                 pad_in,
  output logic                 pad_out,
  output logic                 pad_oe,
  output logic                 pad_analog,
  output logic                 din,
  output src_e                 src,
  output logic [NPER-1:0]      grant
);
  logic [NPER-1:0]   elig;
  logic [PIDX_W-1:0] win;

  assign elig = per_claim & {NPER{fsel}};
  assign win  = pick_winner(elig, prio);

  always_comb begin
    src        = SRC_GPIO;
    pad_out    = odat;
    pad_oe     = dir;
    pad_analog = 1'b0;
    grant      = '0;
    if (dbg_claim) begin
      src     = SRC_DBG;
      pad_out = dbg_out;
      pad_oe  = dbg_oe;
    end else if (osc_claim) begin
      src        = SRC_OSC;
      pad_out    = 1'b0;
      pad_oe     = 1'b0;
      pad_analog = 1'b1;
    end else if (aud_claim) begin
      src     = SRC_AUD;
      pad_out = aud_out;
      pad_oe  = aud_oe;
    end else if (aen) begin
      src        = SRC_AEN;
      pad_out    = 1'b0;
      pad_oe     = 1'b0;
      pad_analog = 1'b1;
    end else if (rf_claim) begin
      src     = SRC_RF;
      pad_out = rf_out;
      pad_oe  = 1'b1;
    end else if (|elig) begin
      src = SRC_PER;
      for (int k = 0; k < NPER; k++)
        if (PIDX_W'(k) == win) begin
          grant[k] = 1'b1;
          pad_out  = per_out_v[k];
          pad_oe   = per_oe_v[k];
        end
    end
  end

  assign din = pad_analog ? 1'b0 : pad_in;

  assert_analog_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pad_analog |-> (!pad_oe && !din));
  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_needs_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> (fsel && |(grant & per_claim)));
  assert_gpio_follows_regs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_GPIO) |-> (pad_out == odat && pad_oe == dir && !pad_analog));
endmodule

// File: rtl/pinmux_arbiter.sv
module pinmux_arbiter
  import pinmux_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [DW-1:0]        cfg_wdata,
  input  logic [NPIN-1:0]      pad_in,
  output logic [NPIN-1:0]      pad_out,
  output logic [NPIN-1:0]      pad_oe,
  output logic [NPIN-1:0]      pad_analog,
  output logic [NPIN-1:0]      gpio_in,
  input  logic [NPER*NSIG-1:0] per_out,
  input  logic [NPER*NSIG-1:0] per_oe,
  output logic [NPER*NSIG-1:0] per_in,
  input  logic                 aud_sck_out,
  input  logic                 aud_sck_oe,
  input  logic                 aud_ws_out,
  input  logic                 aud_ws_oe,
  input  logic                 aud_tx_out,
  output logic                 aud_sck_in,
  output logic                 aud_ws_in,
  output logic                 aud_rx_in,
  input  logic                 dbg_active,
  input  logic                 dbg_dat_out,
  input  logic                 dbg_dat_oe,
  output logic                 dbg_dat_in,
  output logic                 dbg_clk_in,
  input  logic [NRF-1:0]       rf_status,
  output logic                 conv_trig
);
  cfg_t cfg;
  src_e src_m [NPIN];
  logic [NPER-1:0] grant_m [NPIN];
  logic [NPIN-1:0] din;

  pinmux_cfg_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    localparam bit IS_DDAT = (p == PIN_DDAT);
    localparam bit IS_DBG  = (p == PIN_DDAT) || (p == PIN_DCLK);
    localparam bit IS_XO   = (p == PIN_XO0) || (p == PIN_XO1);
    localparam bit IS_P0   = (p < PW);
    localparam bit IS_RF   = (p >= PIN_RF0) && (p < PIN_RF0 + NRF);
    localparam int RFI     = IS_RF ? (p - PIN_RF0) : 0;

    logic [NPER-1:0]  pc, po, pe;
    logic [NROLE-1:0] role;
    logic a_claim, a_out, a_oe, r_claim;
    src_e s_w;
    logic [NPER-1:0] g_w;

    always_comb begin
      pc = '0;
      po = '0;
      pe = '0;
      for (int k = 0; k < NPER; k++)
        for (int s = 0; s < NSIG; s++)
          if (per_pin(k, cfg.per_loc[k], s) == p) begin
            pc[k] = 1'b1;
            po[k] = per_out[k*NSIG + s];
            pe[k] = per_oe[k*NSIG + s];
          end
      for (int r = 0; r < NROLE; r++)
        role[r] = cfg.aud_en && (aud_pin(cfg.aud_loc, r) == p);
    end

    assign a_claim = |role;
    assign a_out   = (role[0] & aud_sck_out) | (role[1] & aud_ws_out) | (role[3] & aud_tx_out);
    assign a_oe    = (role[0] & aud_sck_oe)  | (role[1] & aud_ws_oe)  | role[3];
    assign r_claim = IS_RF && (cfg.rf_cfg[RFI] != '0) && !cfg.aud_en;

    pinmux_pin_resolve u_res (
      .clk        (clk),
      .rst_n      (rst_n),
      .dbg_claim  (IS_DBG && dbg_active),
      .dbg_out    (IS_DDAT && dbg_dat_out),
      .dbg_oe     (IS_DDAT && dbg_dat_oe),
      .osc_claim  (IS_XO && !cfg.osc_sel),
      .aud_claim  (a_claim),
      .aud_out    (a_out),
      .aud_oe     (a_oe),
      .aen        (IS_P0 && cfg.aen[p % PW]),
      .rf_claim   (r_claim),
      .rf_out     (rf_status[RFI]),
      .per_claim  (pc),
      .per_out_v  (po),
      .per_oe_v   (pe),
      .prio       (cfg.prio),
      .fsel       (cfg.fsel[p / PW][p % PW]),
      .dir        (cfg.dir[p / PW][p % PW]),
      .odat       (cfg.odat[p / PW][p % PW]),
      .pad_in     (pad_in[p]),
      .pad_out    (pad_out[p]),
      .pad_oe     (pad_oe[p]),
      .pad_analog (pad_analog[p]),
      .din        (din[p]),
      .src        (s_w),
      .grant      (g_w)
    );

    assign src_m[p]   = s_w;
    assign grant_m[p] = g_w;

    if (IS_RF) begin : g_rf_chk
      assert_radio_drives_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.rf_cfg[RFI] != '0 && !cfg.aud_en && !cfg.aen[0] && !dbg_active)
          |-> (pad_oe[p] && pad_out[p] == rf_status[RFI]));
      assert_radio_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.aud_en |-> (src_m[p] != SRC_RF));
    end
  end

  assign gpio_in = din;

  always_comb begin
    int pin;
    per_in = '0;
    for (int k = 0; k < NPER; k++)
      for (int s = 0; s < NSIG; s++) begin
        pin = per_pin(k, cfg.per_loc[k], s);
        per_in[k*NSIG + s] = grant_m[pin][k] & din[pin];
      end
  end

  always_comb begin
    int pc_i, pw_i, pr_i;
    pc_i = aud_pin(cfg.aud_loc, 0);
    pw_i = aud_pin(cfg.aud_loc, 1);
    pr_i = aud_pin(cfg.aud_loc, 2);
    aud_sck_in = (src_m[pc_i] == SRC_AUD) & din[pc_i];
    aud_ws_in  = (src_m[pw_i] == SRC_AUD) & din[pw_i];
    aud_rx_in  = (src_m[pr_i] == SRC_AUD) & din[pr_i];
  end

  assign dbg_dat_in = (src_m[PIN_DDAT] == SRC_DBG) & din[PIN_DDAT];
  assign dbg_clk_in = (src_m[PIN_DCLK] == SRC_DBG) & din[PIN_DCLK];
  assign conv_trig  = !cfg.fsel[PIN_TRIG / PW][PIN_TRIG % PW]
                    && !cfg.dir[PIN_TRIG / PW][PIN_TRIG % PW]
                    && din[PIN_TRIG];

  assert_trig_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_trig |-> (pad_in[PIN_TRIG] && !pad_oe[PIN_TRIG]));
  assert_debug_owns_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_active |-> (pad_oe[PIN_DDAT] == dbg_dat_oe && !pad_oe[PIN_DCLK]
                    && dbg_clk_in == pad_in[PIN_DCLK]));
  assert_debug_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_active |-> (!dbg_dat_in && !dbg_clk_in));
  assert_osc_analog_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.osc_sel |-> (pad_analog[PIN_XO0] && pad_analog[PIN_XO1]));
  assert_audio_tx_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.aud_en && !dbg_active) |-> pad_oe[aud_pin(cfg.aud_loc, 3)]);
endmodule

// File: tb/pinmux_arbiter_tb_top.sv
module pinmux_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_FSEL0 = 4'd0, A_FSEL1 = 4'd1, A_FSEL2 = 4'd2;
  localparam logic [3:0] A_DIR0 = 4'd3, A_DIR1 = 4'd4, A_DIR2 = 4'd5;
  localparam logic [3:0] A_ODAT0 = 4'd6;
  localparam logic [3:0] A_AEN = 4'd9, A_LOC = 4'd10, A_PRIO = 4'd11;
  localparam logic [3:0] A_RF = 4'd12, A_OSC = 4'd13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [23:0] pad_in = '0;
  logic [23:0] pad_out, pad_oe, pad_analog, gpio_in;
  logic [5:0] per_out = '0, per_oe = '0, per_in;
  logic aud_sck_out = 0, aud_sck_oe = 0, aud_ws_out = 0, aud_ws_oe = 0, aud_tx_out = 0;
  logic aud_sck_in, aud_ws_in, aud_rx_in;
  logic dbg_active = 0, dbg_dat_out = 0, dbg_dat_oe = 0;
  logic dbg_dat_in, dbg_clk_in;
  logic [2:0] rf_status = '0;
  logic conv_trig;
  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pinmux_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_analog(pad_analog),
    .gpio_in(gpio_in), .per_out(per_out), .per_oe(per_oe), .per_in(per_in),
    .aud_sck_out(aud_sck_out), .aud_sck_oe(aud_sck_oe), .aud_ws_out(aud_ws_out),
    .aud_ws_oe(aud_ws_oe), .aud_tx_out(aud_tx_out), .aud_sck_in(aud_sck_in),
    .aud_ws_in(aud_ws_in), .aud_rx_in(aud_rx_in), .dbg_active(dbg_active),
    .dbg_dat_out(dbg_dat_out), .dbg_dat_oe(dbg_dat_oe), .dbg_dat_in(dbg_dat_in),
    .dbg_clk_in(dbg_clk_in), .rf_status(rf_status), .conv_trig(conv_trig)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pad_in = '0; per_out = '0; per_oe = '0; rf_status = '0;
    dbg_active = 0; dbg_dat_out = 0; dbg_dat_oe = 0;
    aud_sck_out = 0; aud_sck_oe = 0; aud_ws_out = 0; aud_ws_oe = 0; aud_tx_out = 0;
    @(negedge clk);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_analog", pad_analog, 0);
    chk("R1 conv_trig", conv_trig, 0);
  endtask

  task automatic t_gpio_and_writes();
    do_reset();
    wr(A_ODAT0, 8'hA5);
    wr(A_DIR0, 8'hF0);
    pad_in = 24'h3C5AC3;
    settle();
    chk("R2 pad_out", pad_out[7:0], 8'hA5);
    chk("R2 pad_oe", pad_oe[7:0], 8'hF0);
    chk("R2 gpio_in", gpio_in, 24'h3C5AC3);
    // R12: ignored address and no strobe leave everything as it was.
    wr(4'd15, 8'hFF);
    wr(4'd14, 8'hFF);
    @(negedge clk);
    cfg_addr = A_DIR0; cfg_wdata = 8'h00;
    @(negedge clk);
    settle();
    chk("R12 no effect", {pad_oe, pad_out[7:0], pad_analog}, {24'h0000F0, 8'hA5, 24'h0});
  endtask

  task automatic t_periph_map();
    do_reset();
    wr(A_FSEL1, 8'h0F);
    wr(A_FSEL0, 8'hC0);
    per_out = 6'b10_01_11;
    per_oe  = 6'b11_10_11;
    pad_in  = 24'h000A40;
    settle();
    chk("R3 p1 out", pad_out[11:8], 4'b1101);
    chk("R3 p1 oe", pad_oe[11:8], 4'b1110);
    chk("R3 p0 out", pad_out[7:6], 2'b10);
    chk("R3 per_in", per_in, 6'b01_10_10);
  endtask

  task automatic t_priority();
    do_reset();
    wr(A_LOC, 8'b0000_0110);
    wr(A_FSEL1, 8'h0C);
    per_out = 6'b11_10_01;
    per_oe  = 6'b11_11_11;
    pad_in  = 24'h000C00;
    wr(A_PRIO, 3'b000); settle();
    chk("R4 three-way prio=000 winner 0", pad_out[11:10], 2'b01);
    wr(A_PRIO, 3'b001); settle();
    chk("R4 three-way prio=001 winner 1", pad_out[11:10], 2'b10);
    chk("R4 per_in to winner only", per_in, 6'b00_11_00);
    wr(A_PRIO, 3'b110); settle();
    chk("R4 three-way prio=110 winner 2", pad_out[11:10], 2'b11);
    chk("R4 per_in to winner 2", per_in, 6'b11_00_00);
    wr(A_LOC, 8'b0000_0010);
    wr(A_PRIO, 3'b001); settle();
    chk("R4 pair prio=001 winner 1", pad_out[11:10], 2'b10);
    wr(A_PRIO, 3'b110); settle();
    chk("R4 pair prio=110 winner 0", pad_out[11:10], 2'b01);
  endtask

  task automatic t_inconclusive();
    do_reset();
    wr(A_LOC, 8'b0000_0110);
    wr(A_FSEL1, 8'h0C);
    per_out = 6'b11_10_01;
    per_oe  = 6'b11_11_11;
    wr(A_PRIO, 3'b011); settle();
    chk("R5 cycle prio=011 lowest wins", pad_out[11:10], 2'b01);
    wr(A_PRIO, 3'b100); settle();
    chk("R5 cycle prio=100 lowest wins", pad_out[11:10], 2'b01);
  endtask

  task automatic t_audio();
    do_reset();
    wr(A_FSEL1, 8'hFF);
    wr(A_RF, 8'h15);
    wr(A_LOC, 8'b0001_0000);
    aud_sck_out = 1; aud_sck_oe = 1; aud_ws_out = 0; aud_ws_oe = 1; aud_tx_out = 1;
    pad_in = 24'h004000;
    settle();
    chk("R6 loc0 oe", pad_oe[15:12], 4'b1011);
    chk("R6 loc0 out", pad_out[15:12], 4'b1001);
    chk("R6 rx routed", aud_rx_in, 1'b1);
    wr(A_LOC, 8'b0001_1000);
    wr(A_AEN, 8'hFF);
    pad_in = 24'h000004;
    settle();
    chk("R6 loc1 beats analog-enable", pad_analog[5:0], 6'b000011);
    chk("R6 loc1 oe", pad_oe[5:2], 4'b1011);
    chk("R6 loc1 clock in", aud_sck_in, 1'b1);
    chk("R8 radio blocked by audio", pad_oe[15:13], 3'b000);
  endtask

  task automatic t_radio();
    do_reset();
    wr(A_RF, 8'h31);
    rf_status = 3'b101;
    settle();
    chk("R8 radio oe", pad_oe[15:13], 3'b101);
    chk("R8 radio out", {pad_out[15], pad_out[13]}, 2'b11);
    rf_status = 3'b010;
    settle();
    chk("R8 radio follows status", {pad_out[15], pad_out[13]}, 2'b00);
  endtask

  task automatic t_analog();
    do_reset();
    wr(A_FSEL0, 8'hFF);
    wr(A_DIR0, 8'hFF);
    wr(A_LOC, 8'b0000_0001);
    wr(A_AEN, 8'h0F);
    per_oe = 6'b11_11_11;
    per_out = 6'b11_11_11;
    pad_in = 24'h0000FF;
    settle();
    chk("R7 analog flags", pad_analog[7:0], 8'h0F);
    chk("R7 oe low on analog", pad_oe[7:0], 8'hF0);
    chk("R7 gpio_in zero", gpio_in[7:0], 8'hF0);
    chk("R7 per_in zero", per_in[1:0], 2'b00);
  endtask

  task automatic t_osc();
    do_reset();
    wr(A_DIR2, 8'hFF);
    wr(A_OSC, 8'h00);
    pad_in = 24'h180000;
    settle();
    chk("R9 xosc analog", pad_analog[20:19], 2'b11);
    chk("R9 xosc oe", pad_oe[21:19], 3'b100);
    chk("R9 xosc input zero", gpio_in[20:19], 2'b00);
    wr(A_OSC, 8'h01);
    settle();
    chk("R9 xosc released", {pad_analog[20:19], pad_oe[20:19]}, 4'b0011);
  endtask

  task automatic t_debug();
    do_reset();
    wr(A_FSEL2, 8'hFF);
    wr(A_DIR2, 8'h04);
    dbg_active = 1; dbg_dat_out = 1; dbg_dat_oe = 1;
    pad_in = 24'h040000;
    settle();
    chk("R10 data drives", {pad_oe[17], pad_out[17]}, 2'b11);
    chk("R10 clock input", pad_oe[18], 1'b0);
    chk("R10 clock routed", dbg_clk_in, 1'b1);
    dbg_dat_oe = 0;
    pad_in = 24'h060000;
    settle();
    chk("R10 data read", {pad_oe[17], dbg_dat_in}, 2'b01);
    dbg_active = 0;
    settle();
    chk("R10 inactive", {pad_oe[18], dbg_clk_in, dbg_dat_in}, 3'b100);
  endtask

  task automatic t_trigger();
    do_reset();
    pad_in = 24'h010000;
    settle();
    chk("R11 trigger as gpio input", conv_trig, 1'b1);
    wr(A_DIR2, 8'h01); settle();
    chk("R11 trigger off as output", conv_trig, 1'b0);
    wr(A_DIR2, 8'h00);
    wr(A_FSEL2, 8'h01); settle();
    chk("R11 trigger off as peripheral", conv_trig, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_gpio_and_writes();
    t_periph_map();
    t_priority();
    t_inconclusive();
    t_audio();
    t_radio();
    t_analog();
    t_osc();
    t_debug();
    t_trigger();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule